// File: doc/BRIEF.md
# Subroutine Call and Return Sequencer

This block controls the program counter whenever an 8-bit microcontroller core transfers control through its stack or through a table. The decoder hands it a control-transfer opcode, an address operand, the address of the current instruction and the accumulator. The sequencer then saves or restores the return address as two bytes in data memory, moves the stack pointer and computes the next program counter. It can also set the global interrupt enable flag, or mark the following instruction to be skipped. The stack pointer is owned here. It points at the next free byte and the stack grows toward lower addresses.

Each operation occupies the unit for a fixed number of cycles, and that number is reported on `op_dur` while `busy` is high. The sequencer is a state machine with the states IDLE, PUSH_LO, PUSH_HI, POP_LO, POP_HI, TABLE, DRAIN and SKIP. An accepted opcode moves IDLE to one of the following states:
- PUSH_LO for a call or software interrupt.
- POP_LO for any return.
- TABLE for the indirect jump.
- DRAIN for a no-op.
- SKIP when a skip is pending.

From there the machine steps PUSH_LO→PUSH_HI→DRAIN, POP_LO→POP_HI→DRAIN and TABLE→DRAIN. It stays in DRAIN or SKIP while cycles remain. From any state it returns to IDLE in the last cycle of the operation, which is the cycle where `pc_load` pulses.

Top module: `subr_ctl`

## Requirements
- R1: While reset is low and after it is released, busy, pc_load, mem_we, mem_re, gie and skip_pend are 0 and sp equals 0x6F.
- R2: A long call (op_code 1, 3 bytes) writes (cur_pc+3)[7:0] at address sp in the first busy cycle and (cur_pc+3)[15:8] at sp−1 in the second. Afterwards sp is lowered by 2, and pc_next equals op_addr.
- R3: A short call (op_code 2, 2 bytes) pushes cur_pc+2 with the same order and addresses as R2 and lowers sp by 2. pc_next takes cur_pc[15:10] for its upper bits and op_addr[9:0] for its lower bits.
- R4: A return (op_code 3, 1 byte) reads the low byte at sp+2 in the first busy cycle and the high byte at sp+1 in the second. It raises sp by 2, and pc_next is the byte pair that was read.
- R5: Return-and-skip (op_code 4) behaves as R4 and then sets skip_pend. The next accepted opcode is discarded: busy lasts one cycle per byte of that opcode, there is no memory access, sp is unchanged, pc_next is cur_pc plus its length, and skip_pend then clears.
- R6: Return-from-interrupt (op_code 5) behaves as R4 and sets gie to 1 at the end of the operation.
- R7: A software interrupt (op_code 7, 1 byte) pushes cur_pc+1 as in R2, lowers sp by 2, and gives pc_next = 0x00FF.
- R8: The indirect jump (op_code 6, 1 byte) drives rom_addr = {cur_pc[15:8], accum}. pc_next is {cur_pc[15:8], rom_rdata}, with no memory access and no sp change.
- R9: busy is high for exactly the operation's duration, which op_dur reports. The durations are 5 cycles for both calls and all three returns, 3 for the indirect jump, 7 for the software interrupt and 1 for the no-op (op_code 0).
- R10: op_valid while busy is high is ignored. This includes the last busy cycle.
- R11: sp wraps modulo 256 in both directions.
- R12: pc_load is high in exactly one cycle per operation, the last busy cycle, and pc_next is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Opcode offered this cycle |
| op_code | input | 3 | Control-transfer opcode |
| op_addr | input | 16 | Address operand |
| cur_pc | input | 16 | Address of the current instruction |
| accum | input | 8 | Accumulator value |
| busy | output | 1 | Operation in progress |
| op_dur | output | 3 | Duration of the current operation in cycles |
| pc_next | output | 16 | New program counter |
| pc_load | output | 1 | pc_next valid, last cycle |
| sp | output | 8 | Stack pointer |
| gie | output | 1 | Global interrupt enable |
| skip_pend | output | 1 | Next opcode will be skipped |
| mem_we | output | 1 | Data memory write strobe |
| mem_re | output | 1 | Data memory read strobe |
| mem_addr | output | 8 | Data memory address |
| mem_wdata | output | 8 | Data memory write byte |
| mem_rdata | input | 8 | Data memory read byte (same cycle) |
| rom_addr | output | 16 | Table ROM address |
| rom_rdata | input | 8 | Table ROM byte (same cycle) |

## Verification
Two functions can coincide in one cycle: completion of an operation, with its pc_load pulse, and arrival of a new op_valid. A second collision occurs when a pending skip meets the acceptance of a real call. The bench raises op_valid in the second busy cycle and again in the final busy cycle. It then judges that neither the duration, the stack pointer nor the memory traffic changes, and that no new operation starts. After a return-and-skip it offers a long call and expects a silent three-cycle discard.

// File: rtl/subr_pkg.sv
package subr_pkg;

    typedef enum logic [2:0] {
        OP_NOP      = 3'd0,
        OP_CALL_L   = 3'd1,
        OP_CALL_S   = 3'd2,
        OP_RET      = 3'd3,
        OP_RET_SKIP = 3'd4,
        OP_RET_INT  = 3'd5,
        OP_JMP_IND  = 3'd6,
        OP_SWI      = 3'd7
    } xfer_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_LO,
        ST_PUSH_HI,
        ST_POP_LO,
        ST_POP_HI,
        ST_TABLE,
        ST_DRAIN,
        ST_SKIP
    } seq_st_e;

    // instruction length in bytes
    function automatic logic [2:0] op_bytes(xfer_op_e op);
        case (op)
            OP_CALL_L: return 3'd3;
            OP_CALL_S: return 3'd2;
            default:   return 3'd1;
        endcase
    endfunction

    // execution time in cycles
    function automatic logic [2:0] op_cycles(xfer_op_e op);
        case (op)
            OP_NOP:     return 3'd1;
            OP_JMP_IND: return 3'd3;
            OP_SWI:     return 3'd7;
            default:    return 3'd5;
        endcase
    endfunction

endpackage

// File: rtl/subr_fsm.sv
module subr_fsm
    import subr_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             skip_mode,
    input  xfer_op_e         op,
    input  logic [CNT_W-1:0] dur_in,
    output seq_st_e          state,
    output logic             busy,
    output logic             last,
    output logic [CNT_W-1:0] dur
);

    seq_st_e          state_q, state_d;
    logic [CNT_W-1:0] remain_q;
    logic [CNT_W-1:0] dur_q;
    logic             busy_w, last_w;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (skip_mode) begin
                        state_d = ST_SKIP;
                    end else begin
                        unique case (op)
                            OP_CALL_L, OP_CALL_S, OP_SWI:      state_d = ST_PUSH_LO;
                            OP_RET, OP_RET_SKIP, OP_RET_INT:   state_d = ST_POP_LO;
                            OP_JMP_IND:                        state_d = ST_TABLE;
                            OP_NOP:                            state_d = ST_DRAIN;
                        endcase
                    end
                end
            end
            ST_PUSH_LO: state_d = ST_PUSH_HI;
            ST_PUSH_HI: state_d = ST_DRAIN;
            ST_POP_LO:  state_d = ST_POP_HI;
            ST_POP_HI:  state_d = ST_DRAIN;
            ST_TABLE:   state_d = ST_DRAIN;
            ST_DRAIN:   state_d = ST_DRAIN;
            ST_SKIP:    state_d = ST_SKIP;
        endcase
        if (last_w) state_d = ST_IDLE;
    end

    // state register and cycle budget
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            remain_q <= '0;
            dur_q    <= '0;
        end else begin
            state_q <= state_d;
            if (start && !busy_w) begin
                remain_q <= dur_in - CNT_W'(1);
                dur_q    <= dur_in;
            end else if (busy_w && remain_q != '0) begin
                remain_q <= remain_q - CNT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        busy_w = (state_q != ST_IDLE);
        last_w = busy_w && (remain_q == '0);
        state  = state_q;
        busy   = busy_w;
        last   = last_w;
        dur    = dur_q;
    end

endmodule

// File: rtl/subr_dp.sv
module subr_dp
    import subr_pkg::*;
#(
    parameter int             PC_W    = 16,
    parameter int             ADDR_W  = 8,
    parameter int             SHORT_W = 10,
    parameter logic [ADDR_W-1:0] SP_RST  = 8'h6F,
    parameter logic [PC_W-1:0]   SWI_VEC = 16'h00FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  xfer_op_e          op,
    input  logic [PC_W-1:0]   cur_pc,
    input  logic [PC_W-1:0]   op_addr,
    input  logic [7:0]        accum,
    input  seq_st_e           state,
    input  logic              last,
    input  logic [7:0]        mem_rdata,
    input  logic [7:0]        rom_rdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic [PC_W-1:0]   rom_addr,
    output logic [ADDR_W-1:0] sp,
    output logic [PC_W-1:0]   pc_next,
    output logic              pc_load,
    output logic              gie,
    output logic              skip_pend
);

    localparam int HI_W = PC_W - 8;

    xfer_op_e          op_q;
    logic [PC_W-1:0]   ret_q, base_q, opnd_q, pop_q;
    logic [7:0]        acc_q;
    logic [ADDR_W-1:0] sp_q;
    logic              gie_q, skip_q, skipping_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q       <= OP_NOP;
            ret_q      <= '0;
            base_q     <= '0;
            opnd_q     <= '0;
            pop_q      <= '0;
            acc_q      <= '0;
            sp_q       <= SP_RST;
            gie_q      <= 1'b0;
            skip_q     <= 1'b0;
            skipping_q <= 1'b0;
        end else begin
            if (start) begin
                op_q       <= op;
                base_q     <= cur_pc;
                opnd_q     <= op_addr;
                acc_q      <= accum;
                ret_q      <= cur_pc + PC_W'(op_bytes(op));
                skipping_q <= skip_q;
            end
            case (state)
                ST_PUSH_HI: sp_q <= sp_q - ADDR_W'(2);
                ST_POP_LO:  pop_q[7:0] <= mem_rdata;
                ST_POP_HI: begin
                    pop_q[PC_W-1:8] <= mem_rdata[HI_W-1:0];
                    sp_q            <= sp_q + ADDR_W'(2);
                end
                ST_TABLE:   pop_q[7:0] <= rom_rdata;
                default: ;
            endcase
            if (last) begin
                if (skipping_q) begin
                    skip_q <= 1'b0;
                end else begin
                    if (op_q == OP_RET_INT)  gie_q  <= 1'b1;
                    if (op_q == OP_RET_SKIP) skip_q <= 1'b1;
                end
            end
        end
    end

    // stack traffic
    always_comb begin
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = sp_q;
        mem_wdata = 8'h00;
        case (state)
            ST_PUSH_LO: begin
                mem_we    = 1'b1;
                mem_wdata = ret_q[7:0];
            end
            ST_PUSH_HI: begin
                mem_we    = 1'b1;
                mem_addr  = sp_q - ADDR_W'(1);
                mem_wdata = 8'(ret_q[PC_W-1:8]);
            end
            ST_POP_LO: begin
                mem_re   = 1'b1;
                mem_addr = sp_q + ADDR_W'(2);
            end
            ST_POP_HI: begin
                mem_re   = 1'b1;
                mem_addr = sp_q + ADDR_W'(1);
            end
            default: ;
        endcase
    end

    // target selection
    always_comb begin
        if (skipping_q) begin
            pc_next = ret_q;
        end else begin
            case (op_q)
                OP_CALL_L:  pc_next = opnd_q;
                OP_CALL_S:  pc_next = {base_q[PC_W-1:SHORT_W], opnd_q[SHORT_W-1:0]};
                OP_SWI:     pc_next = SWI_VEC;
                OP_RET, OP_RET_SKIP, OP_RET_INT: pc_next = pop_q;
                OP_JMP_IND: pc_next = {base_q[PC_W-1:8], pop_q[7:0]};
                default:    pc_next = ret_q;
            endcase
        end
    end

    assign rom_addr  = {base_q[PC_W-1:8], acc_q};
    assign sp        = sp_q;
    assign pc_load   = last;
    assign gie       = gie_q;
    assign skip_pend = skip_q;

endmodule

// File: rtl/subr_ctl.sv
module subr_ctl
    import subr_pkg::*;
#(
    parameter int PC_W    = 16,
    parameter int ADDR_W  = 8,
    parameter int SHORT_W = 10,
    parameter int CNT_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_code,
    input  logic [PC_W-1:0]   op_addr,
    input  logic [PC_W-1:0]   cur_pc,
    input  logic [7:0]        accum,
    output logic              busy,
    output logic [CNT_W-1:0]  op_dur,
    output logic [PC_W-1:0]   pc_next,
    output logic              pc_load,
    output logic [ADDR_W-1:0] sp,
    output logic              gie,
    output logic              skip_pend,
    output logic              mem_we,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic [PC_W-1:0]   rom_addr,
    input  logic [7:0]        rom_rdata
);

    xfer_op_e         op_e;
    seq_st_e          state;
    logic             start, last, busy_w, skip_w;
    logic [CNT_W-1:0] dur_in;

    assign op_e   = xfer_op_e'(op_code);
    assign start  = op_valid && !busy_w;
    assign dur_in = skip_w ? CNT_W'(op_bytes(op_e)) : CNT_W'(op_cycles(op_e));

    subr_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .skip_mode (skip_w),
        .op        (op_e),
        .dur_in    (dur_in),
        .state     (state),
        .busy      (busy_w),
        .last      (last),
        .dur       (op_dur)
    );

    subr_dp #(
        .PC_W    (PC_W),
        .ADDR_W  (ADDR_W),
        .SHORT_W (SHORT_W)
    ) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op        (op_e),
        .cur_pc    (cur_pc),
        .op_addr   (op_addr),
        .accum     (accum),
        .state     (state),
        .last      (last),
        .mem_rdata (mem_rdata),
        .rom_rdata (rom_rdata),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .rom_addr  (rom_addr),
        .sp        (sp),
        .pc_next   (pc_next),
        .pc_load   (pc_load),
        .gie       (gie),
        .skip_pend (skip_w)
    );

    assign busy      = busy_w;
    assign skip_pend = skip_w;

endmodule

// File: rtl/subr_ctl_chk.sv
module subr_ctl_chk #(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic              busy,
    input logic [CNT_W-1:0]  op_dur,
    input logic              pc_load,
    input logic [ADDR_W-1:0] sp,
    input logic              gie,
    input logic              skip_pend,
    input logic              mem_we,
    input logic              mem_re,
    input logic [ADDR_W-1:0] mem_addr
);

    // R1: reset leaves the unit idle with interrupts disabled
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> !busy && !gie && !skip_pend);

    // R2: the second push byte goes one address below the first
    p_push_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !$past(mem_we)) |=> (mem_we && mem_addr == $past(mem_addr) - ADDR_W'(1)));

    // R5: a discarded opcode touches no memory
    p_skip_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_pend && busy) |-> (!mem_we && !mem_re));

    // R6: the enable flag only rises at the end of an operation
    p_gie_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gie) |-> $past(pc_load));

    // R10: a request while busy does not disturb the running duration
    p_hold_dur_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_valid && !pc_load) |=> $stable(op_dur));

    // R11: the stack pointer only ever moves by two, modulo 256
    p_sp_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sp) |-> (sp == $past(sp) - ADDR_W'(2) || sp == $past(sp) + ADDR_W'(2)));

    // R12: completion is followed by an idle cycle
    p_load_end_r12: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !busy);

endmodule

bind subr_ctl subr_ctl_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .busy      (busy),
    .op_dur    (op_dur),
    .pc_load   (pc_load),
    .sp        (sp),
    .gie       (gie),
    .skip_pend (skip_pend),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_addr  (mem_addr)
);

// File: tb/subr_ctl_tb.sv
`timescale 1ns/1ps
module subr_ctl_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid;
    logic [2:0]  op_code;
    logic [15:0] op_addr, cur_pc;
    logic [7:0]  accum;
    logic        busy, pc_load, gie, skip_pend, mem_we, mem_re;
    logic [2:0]  op_dur;
    logic [15:0] pc_next, rom_addr;
    logic [7:0]  sp, mem_addr, mem_wdata, mem_rdata, rom_rdata;

    logic [7:0] mem [256];
    int nchk = 0;
    int nfail = 0;
    bit ended = 0;

    // model state
    logic [7:0] m_sp;
    logic       m_gie, m_skip;

    always #4 clk = ~clk;

    subr_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_addr(op_addr), .cur_pc(cur_pc), .accum(accum), .busy(busy),
        .op_dur(op_dur), .pc_next(pc_next), .pc_load(pc_load), .sp(sp),
        .gie(gie), .skip_pend(skip_pend), .mem_we(mem_we), .mem_re(mem_re),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rom_addr(rom_addr), .rom_rdata(rom_rdata)
    );

    assign mem_rdata = mem[mem_addr];
    assign rom_rdata = rom_addr[7:0] ^ rom_addr[15:8] ^ 8'h5A;

    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

    // {op, addr, pc, acc, inject cycle}
    localparam logic [45:0] VEC [9] = '{
        {3'd1, 16'h4567, 16'h1230, 8'h00, 3'd0},
        {3'd2, 16'h03AB, 16'h4567, 8'h00, 3'd2},
        {3'd7, 16'h0000, 16'h07A0, 8'h00, 3'd7},
        {3'd6, 16'h0000, 16'h2C10, 8'h93, 3'd0},
        {3'd3, 16'h0000, 16'h00FF, 8'h00, 3'd5},
        {3'd5, 16'h0000, 16'h0811, 8'h00, 3'd0},
        {3'd4, 16'h0000, 16'h4570, 8'h00, 3'd0},
        {3'd1, 16'h7777, 16'h1233, 8'h00, 3'd0},
        {3'd0, 16'h0000, 16'h1236, 8'h00, 3'd0}
    };

    function automatic int blen(logic [2:0] op);
        return (op == 3'd1) ? 3 : (op == 3'd2) ? 2 : 1;
    endfunction

    function automatic int bcyc(logic [2:0] op);
        return (op == 3'd0) ? 1 : (op == 3'd6) ? 3 : (op == 3'd7) ? 7 : 5;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; op_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", "busy in reset", {31'd0, busy}, 32'd0);
        chk("R1", "mem_we in reset", {31'd0, mem_we}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy after reset", {31'd0, busy}, 32'd0);
        chk("R1", "gie after reset", {31'd0, gie}, 32'd0);
        chk("R1", "skip after reset", {31'd0, skip_pend}, 32'd0);
        chk("R1", "pc_load after reset", {31'd0, pc_load}, 32'd0);
        chk("R1", "sp after reset", {24'd0, sp}, 32'h6F);
        m_sp = 8'h6F; m_gie = 1'b0; m_skip = 1'b0;
    endtask

    task automatic run_op(input logic [2:0] op, input logic [15:0] addr, input logic [15:0] pc,
                          input logic [7:0] acc, input int inj);
        string tag;
        logic [15:0] ret, exp_pc;
        logic [7:0]  exp_sp;
        int n, nload;
        bit skipped, push, pop;
        logic        we_c [8];
        logic        re_c [8];
        logic [7:0]  ad_c [8];
        logic [7:0]  wd_c [8];
        logic [15:0] ra_c, pcn;
        skipped = m_skip;
        ret  = pc + 16'(blen(op));
        push = !skipped && (op == 3'd1 || op == 3'd2 || op == 3'd7);
        pop  = !skipped && (op == 3'd3 || op == 3'd4 || op == 3'd5);
        n    = skipped ? blen(op) : bcyc(op);
        exp_sp = m_sp;
        case (op)
            3'd1: begin tag = "R2"; exp_pc = addr; end
            3'd2: begin tag = "R3"; exp_pc = {pc[15:10], addr[9:0]}; end
            3'd3: tag = "R4";
            3'd4: tag = "R5";
            3'd5: tag = "R6";
            3'd6: begin tag = "R8"; exp_pc = {pc[15:8], pc[15:8] ^ acc ^ 8'h5A}; end
            3'd7: begin tag = "R7"; exp_pc = 16'h00FF; end
            default: begin tag = "R9"; exp_pc = ret; end
        endcase
        if (pop) exp_pc = {mem[8'(m_sp + 8'd1)], mem[8'(m_sp + 8'd2)]};
        if (push) exp_sp = m_sp - 8'd2;
        if (pop) exp_sp = m_sp + 8'd2;
        if (skipped) begin tag = "R5"; exp_pc = ret; end

        @(negedge clk);
        chk("R10", "idle before issue", {31'd0, busy}, 32'd0);
        op_valid = 1'b1; op_code = op; op_addr = addr; cur_pc = pc; accum = acc;
        @(posedge clk);
        nload = 0; pcn = 16'h0; ra_c = 16'h0;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            chk("R9", "busy", {31'd0, busy}, 32'd1);
            if (k == 1) chk("R9", "op_dur", {29'd0, op_dur}, 32'(n));
            if (k < 8) begin
                we_c[k] = mem_we; re_c[k] = mem_re; ad_c[k] = mem_addr; wd_c[k] = mem_wdata;
            end
            if (k == 1) ra_c = rom_addr;
            if (pc_load) begin
                nload++;
                pcn = pc_next;
                chk("R12", "pc_load cycle", 32'(k), 32'(n));
            end
            if (k == inj) begin op_valid = 1'b1; op_code = 3'd7; end
            else op_valid = 1'b0;
        end
        @(negedge clk);
        op_valid = 1'b0;
        chk("R12", "pc_load count", 32'(nload), 32'd1);
        chk(tag, "pc_next", {16'd0, pcn}, {16'd0, exp_pc});
        chk(inj != 0 ? "R10" : "R9", "idle after duration", {31'd0, busy}, 32'd0);
        chk((push && exp_sp > m_sp) || (pop && exp_sp < m_sp) ? "R11" : tag,
            "sp", {24'd0, sp}, {24'd0, exp_sp});
        if (push) begin
            chk(tag, "push lo", {15'd0, we_c[1], ad_c[1], wd_c[1]}, {15'd0, 1'b1, m_sp, ret[7:0]});
            chk(tag, "push hi", {15'd0, we_c[2], ad_c[2], wd_c[2]}, {15'd0, 1'b1, 8'(m_sp - 8'd1), ret[15:8]});
        end else if (pop) begin
            chk(tag, "pop lo", {23'd0, re_c[1], ad_c[1]}, {23'd0, 1'b1, 8'(m_sp + 8'd2)});
            chk(tag, "pop hi", {23'd0, re_c[2], ad_c[2]}, {23'd0, 1'b1, 8'(m_sp + 8'd1)});
        end else begin
            chk(tag, "no memory access", {30'd0, we_c[1] | re_c[1], (n > 1) ? (we_c[2] | re_c[2]) : 1'b0}, 32'd0);
        end
        if (op == 3'd6 && !skipped) chk("R8", "rom_addr", {16'd0, ra_c}, {16'd0, pc[15:8], acc});
        m_sp = exp_sp;
        if (!skipped && op == 3'd5) m_gie = 1'b1;
        if (skipped) m_skip = 1'b0;
        else if (op == 3'd4) m_skip = 1'b1;
        chk(op == 3'd5 ? "R6" : "R1", "gie", {31'd0, gie}, {31'd0, m_gie});
        chk("R5", "skip_pend", {31'd0, skip_pend}, {31'd0, m_skip});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL R9 watchdog expired: actual hung expected done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        rst_n = 1'b0; op_valid = 1'b0; op_code = 3'd0;
        op_addr = 16'h0; cur_pc = 16'h0; accum = 8'h0;
        do_reset();

        // table walk: every opcode, a skip discard, and requests while busy
        for (int v = 0; v < 9; v++)
            run_op(VEC[v][45:43], VEC[v][42:27], VEC[v][26:11], VEC[v][10:3], int'(VEC[v][2:0]));

        // R5 then R1: pending skip and enable cleared by reset
        run_op(3'd4, 16'h0, 16'h0100, 8'h0, 0);
        run_op(3'd5, 16'h0, 16'h0200, 8'h0, 0);
        do_reset();

        // R5: discarded short call and software interrupt
        run_op(3'd4, 16'h0, 16'h0300, 8'h0, 0);
        run_op(3'd2, 16'h0155, 16'h0400, 8'h0, 0);
        run_op(3'd3, 16'h0, 16'h0500, 8'h0, 0);
        run_op(3'd4, 16'h0, 16'h0600, 8'h0, 0);
        run_op(3'd7, 16'h0, 16'h0700, 8'h0, 0);
        do_reset();

        // R11: push across address zero and pop back across it
        for (int c = 0; c < 57; c++)
            run_op(3'd1, 16'h2000 + 16'(c), 16'h8000 + 16'(c * 3), 8'h0, 0);
        chk("R11", "sp after wrap", {24'd0, sp}, 32'hFD);
        for (int r = 0; r < 2; r++)
            run_op(3'd3, 16'h0, 16'h0900, 8'h0, 0);
        chk("R11", "sp after unwrap", {24'd0, sp}, 32'h01);

        // R8: second table lookup with a different accumulator
        run_op(3'd6, 16'h0, 16'hA5F0, 8'h3C, 3);

        finish_run();
    end

endmodule